// File: doc/BRIEF.md
# Serial Audio Link Frame Receiver

This block receives the incoming direction of a frame-based serial audio link. One serial data line and a SYNC line are both driven by the far end on the rising edge of the bit clock. The receiver samples both on the falling edge. A frame is 256 bits long: a 16-bit tag slot followed by twelve 20-bit data slots. The frame begins on the bit where SYNC is first seen high after being low.

The tag slot carries two kinds of flag. Its most significant bit marks the whole frame as valid. The next twelve bits each mark one data slot as carrying data. Slots 1 and 2 return control-register reads, slots 3 and 4 carry two-channel PCM record samples, and one further slot may carry a dedicated microphone stream. This block only collects the words: it does not interpret them.

At the end of each frame the receiver updates its output registers all at once and pulses a done strobe for one cycle. It also flags any slot that is marked empty but holds nonzero data. A SYNC rise that arrives anywhere other than the expected frame start restarts the bit count and produces a sync-error pulse.

Top module: `aclink_rx_frame`

## Requirements
- R1: While reset is high, and on the first sample after reset, every output is zero.
- R2: No frame is decoded until SYNC has been sampled low and then high. Data before that first rise never produces a done strobe and leaves frame_valid_o at 0.
- R3: Tag slot bits arrive MSB first. frame_valid_o takes tag bit 15. slot_valid_o bit i (for slot i+1) takes tag bit 14-i. Tag bits 2..0 are ignored.
- R4: Slot n (1..12) occupies frame bits 16+20(n-1) to 35+20(n-1), MSB first, and appears on slot_data_o[20(n-1) +: 20].
- R5: frame_done_o is high for exactly one falling edge, right after the falling edge that samples frame bit 255. On a clean link it repeats every 256 cycles.
- R6: Between done strobes, frame_valid_o, slot_valid_o, slot_data_o and slot_fill_err_o stay stable. They change only together with the done strobe.
- R7: slot_fill_err_o bit i is 1 when slot i+1 has tag 0 and a nonzero word. A slot tagged valid never raises its error bit.
- R8: A SYNC rise at any bit position other than 0 after alignment pulses sync_err_o for one cycle. It restarts the count so that the rise is bit 0. The interrupted frame produces no done strobe.
- R9: Only the SYNC rise matters for alignment. SYNC held high longer than the 16-bit tag phase does not change decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock; all state changes on its falling edge |
| rst_i | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Frame sync from the link |
| sdata_i | input | 1 | Serial data from the link |
| frame_done_o | output | 1 | One-cycle strobe when a frame's outputs are loaded |
| frame_valid_o | output | 1 | Whole-frame valid flag of the last frame |
| slot_valid_o | output | 12 | Per-slot valid tags, bit i for slot i+1 |
| slot_data_o | output | 240 | Twelve 20-bit slot words, slot 1 in the low bits |
| slot_fill_err_o | output | 12 | Empty slot carried nonzero data, bit i for slot i+1 |
| sync_err_o | output | 1 | SYNC rose away from the frame start |

## Verification
A wrong bit or slot counter shows at the ports in two ways: slot words come out shifted across slot boundaries, or the done strobe lands off its 256-cycle grid. Either becomes visible at the first done strobe after the fault. A wrongly latched tag shows as swapped valid flags, or as error bits set on slots that are tagged valid, in the same frame. Alignment faults show within one cycle of the SYNC rise, through sync_err_o or through a missing or extra done strobe one frame later.

// File: rtl/aclink_rx_pkg.sv
package aclink_rx_pkg;

    // Slot counter width; it holds the tag slot (0) plus the data slots.
    localparam int SLOT_IDX_W = 8;

    typedef logic [SLOT_IDX_W-1:0] slot_idx_t;

    // One sampled bit position as seen by the deserializer.
    typedef struct packed {
        logic      act;    // receiver aligned, this bit belongs to a frame
        logic      last;   // final bit of the current slot
        logic      fend;   // final bit of the whole frame
        slot_idx_t slot;   // 0 = tag slot, 1..N = data slots
    } beat_t;

    // Position, inside the stored tag field [N:0], of data slot g+1's flag.
    function automatic int valid_bit(input int g, input int nslots);
        return nslots - 1 - g;
    endfunction

    // Length of a slot in bits.
    function automatic int slot_len(input int slot, input int tag_w, input int slot_w);
        return (slot == 0) ? tag_w : slot_w;
    endfunction

endpackage

// File: rtl/aclink_rx_align.sv
module aclink_rx_align
    import aclink_rx_pkg::*;
#(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sync_i,
    output beat_t beat_o,
    output logic  sync_err_o
);
    localparam int MAXW = (TAG_W > SLOT_W) ? TAG_W : SLOT_W;
    localparam int PW   = $clog2(MAXW);

    logic            prev_q;
    logic            locked_q;
    logic            serr_q;
    slot_idx_t       slot_q;
    logic [PW-1:0]   pos_q;

    logic            rise;
    logic            active;
    logic            slot_last;
    slot_idx_t       cur_slot;
    logic [PW-1:0]   cur_pos;

    assign rise     = sync_i & ~prev_q;
    assign active   = locked_q | rise;
    assign cur_slot = rise ? '0 : slot_q;
    assign cur_pos  = rise ? '0 : pos_q;

    always_comb begin
        if (cur_slot == '0)
            slot_last = (cur_pos == PW'(slot_len(0, TAG_W, SLOT_W) - 1));
        else
            slot_last = (cur_pos == PW'(slot_len(1, TAG_W, SLOT_W) - 1));
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            prev_q   <= 1'b1;     // a SYNC already high at reset is not a rise
            locked_q <= 1'b0;
            serr_q   <= 1'b0;
            slot_q   <= '0;
            pos_q    <= '0;
        end else begin
            prev_q <= sync_i;
            serr_q <= rise & locked_q & ((slot_q != '0) | (pos_q != '0));
            if (rise)
                locked_q <= 1'b1;
            if (active) begin
                if (slot_last) begin
                    pos_q  <= '0;
                    slot_q <= (cur_slot == slot_idx_t'(NUM_SLOTS)) ? '0 : cur_slot + 1'b1;
                end else begin
                    pos_q  <= cur_pos + 1'b1;
                    slot_q <= cur_slot;
                end
            end
        end
    end

    always_comb begin
        beat_o.act  = active;
        beat_o.last = active & slot_last;
        beat_o.fend = active & slot_last & (cur_slot == slot_idx_t'(NUM_SLOTS));
        beat_o.slot = cur_slot;
    end

    assign sync_err_o = serr_q;

endmodule

// File: rtl/aclink_rx_deser.sv
module aclink_rx_deser
    import aclink_rx_pkg::*;
#(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sdata_i,
    input  beat_t                       beat_i,
    output logic [NUM_SLOTS:0]          tag_o,
    output logic [NUM_SLOTS*SLOT_W-1:0] frame_data_o,
    output logic [NUM_SLOTS-1:0]        frame_err_o
);
    logic [SLOT_W-2:0]   shift_q;
    logic [SLOT_W-1:0]   word;
    logic [NUM_SLOTS:0]  tag_q;

    // Word completed by the bit sampled on this edge, MSB first.
    assign word = {shift_q, sdata_i};

    always_ff @(negedge clk) begin
        if (rst) begin
            shift_q <= '0;
            tag_q   <= '0;
        end else begin
            shift_q <= word[SLOT_W-2:0];
            if (beat_i.last && beat_i.slot == '0)
                tag_q <= word[TAG_W-1 -: NUM_SLOTS+1];
        end
    end

    assign tag_o = tag_q;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam int VB = valid_bit(g, NUM_SLOTS);
        if (g == NUM_SLOTS - 1) begin : g_live
            // The final slot completes on the same edge the frame ends.
            assign frame_data_o[g*SLOT_W +: SLOT_W] = word;
            assign frame_err_o[g] = ~tag_q[VB] & (|word);
        end else begin : g_held
            logic [SLOT_W-1:0] buf_q;
            logic              err_q;
            logic              hit;
            assign hit = beat_i.last && (beat_i.slot == slot_idx_t'(g + 1));
            always_ff @(negedge clk) begin
                if (rst) begin
                    buf_q <= '0;
                    err_q <= 1'b0;
                end else if (hit) begin
                    buf_q <= word;
                    err_q <= ~tag_q[VB] & (|word);
                end
            end
            assign frame_data_o[g*SLOT_W +: SLOT_W] = buf_q;
            assign frame_err_o[g] = err_q;
        end
    end

endmodule

// File: rtl/aclink_rx_outreg.sv
module aclink_rx_outreg
    import aclink_rx_pkg::*;
#(
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  beat_t                       beat_i,
    input  logic [NUM_SLOTS:0]          tag_i,
    input  logic [NUM_SLOTS*SLOT_W-1:0] frame_data_i,
    input  logic [NUM_SLOTS-1:0]        frame_err_i,
    output logic                        done_o,
    output logic                        fvalid_o,
    output logic [NUM_SLOTS-1:0]        svalid_o,
    output logic [NUM_SLOTS*SLOT_W-1:0] data_o,
    output logic [NUM_SLOTS-1:0]        err_o
);
    logic [NUM_SLOTS-1:0] svalid_next;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_tag
        assign svalid_next[g] = tag_i[valid_bit(g, NUM_SLOTS)];
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            done_o   <= 1'b0;
            fvalid_o <= 1'b0;
            svalid_o <= '0;
            data_o   <= '0;
            err_o    <= '0;
        end else begin
            done_o <= beat_i.fend;
            if (beat_i.fend) begin
                fvalid_o <= tag_i[NUM_SLOTS];
                svalid_o <= svalid_next;
                data_o   <= frame_data_i;
                err_o    <= frame_err_i;
            end
        end
    end

endmodule

// File: rtl/aclink_rx_frame.sv
module aclink_rx_frame
    import aclink_rx_pkg::*;
#(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12
) (
    input  logic                        bclk_i,
    input  logic                        rst_i,
    input  logic                        sync_i,
    input  logic                        sdata_i,
    output logic                        frame_done_o,
    output logic                        frame_valid_o,
    output logic [NUM_SLOTS-1:0]        slot_valid_o,
    output logic [NUM_SLOTS*SLOT_W-1:0] slot_data_o,
    output logic [NUM_SLOTS-1:0]        slot_fill_err_o,
    output logic                        sync_err_o
);
    beat_t                       beat;
    logic [NUM_SLOTS:0]          tag;
    logic [NUM_SLOTS*SLOT_W-1:0] frame_data;
    logic [NUM_SLOTS-1:0]        frame_err;

    aclink_rx_align #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
    ) u_align (
        .clk        (bclk_i),
        .rst        (rst_i),
        .sync_i     (sync_i),
        .beat_o     (beat),
        .sync_err_o (sync_err_o)
    );

    aclink_rx_deser #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
    ) u_deser (
        .clk          (bclk_i),
        .rst          (rst_i),
        .sdata_i      (sdata_i),
        .beat_i       (beat),
        .tag_o        (tag),
        .frame_data_o (frame_data),
        .frame_err_o  (frame_err)
    );

    aclink_rx_outreg #(
        .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
    ) u_out (
        .clk          (bclk_i),
        .rst          (rst_i),
        .beat_i       (beat),
        .tag_i        (tag),
        .frame_data_i (frame_data),
        .frame_err_i  (frame_err),
        .done_o       (frame_done_o),
        .fvalid_o     (frame_valid_o),
        .svalid_o     (slot_valid_o),
        .data_o       (slot_data_o),
        .err_o        (slot_fill_err_o)
    );

endmodule

// File: rtl/aclink_rx_frame_chk.sv
module aclink_rx_frame_chk #(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        frame_done,
    input logic                        frame_valid,
    input logic [NUM_SLOTS-1:0]        slot_valid,
    input logic [NUM_SLOTS*SLOT_W-1:0] slot_data,
    input logic [NUM_SLOTS-1:0]        slot_fill_err,
    input logic                        sync_err
);
    localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;

    logic [15:0] gap_q;
    logic        have_prev_q;
    logic        saw_err_q;

    always_ff @(negedge clk) begin
        if (rst) begin
            gap_q       <= '0;
            have_prev_q <= 1'b0;
            saw_err_q   <= 1'b0;
        end else if (frame_done) begin
            gap_q       <= '0;
            have_prev_q <= 1'b1;
            saw_err_q   <= 1'b0;
        end else begin
            if (gap_q != 16'hFFFF)
                gap_q <= gap_q + 16'd1;
            if (sync_err)
                saw_err_q <= 1'b1;
        end
    end

    AST_RESET_CLEAR: assert property (@(negedge clk) disable iff (rst)
        $past(rst) |-> (!frame_done && !frame_valid && slot_valid == '0 &&
                        slot_data == '0 && slot_fill_err == '0 && !sync_err)); // R1

    AST_DONE_SINGLE: assert property (@(negedge clk) disable iff (rst)
        frame_done |=> !frame_done); // R5

    AST_DONE_PERIOD: assert property (@(negedge clk) disable iff (rst)
        (frame_done && have_prev_q && !saw_err_q && !sync_err)
            |-> (gap_q == 16'(FRAME_BITS - 1))); // R5

    AST_HOLD_BETWEEN: assert property (@(negedge clk) disable iff (rst)
        !frame_done |-> ($stable(slot_data) && $stable(slot_valid) &&
                         $stable(frame_valid) && $stable(slot_fill_err))); // R6

    AST_ERR_ONLY_EMPTY: assert property (@(negedge clk) disable iff (rst)
        frame_done |-> ((slot_fill_err & slot_valid) == '0)); // R7

    AST_SYNC_ERR_PULSE: assert property (@(negedge clk) disable iff (rst)
        sync_err |=> !sync_err); // R8

endmodule

bind aclink_rx_frame aclink_rx_frame_chk #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
) u_chk (
    .clk           (bclk_i),
    .rst           (rst_i),
    .frame_done    (frame_done_o),
    .frame_valid   (frame_valid_o),
    .slot_valid    (slot_valid_o),
    .slot_data     (slot_data_o),
    .slot_fill_err (slot_fill_err_o),
    .sync_err      (sync_err_o)
);

// File: tb/aclink_rx_frame_test.sv
`timescale 1ns/1ps
module aclink_rx_frame_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 12;
    localparam int SW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync = 1'b0;
    logic          sdata = 1'b0;
    logic          frame_done, frame_valid, sync_err;
    logic [NS-1:0] slot_valid, slot_fill_err;
    logic [NS*SW-1:0] slot_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Stimulus state
    logic [15:0]   cur_tag;
    logic [SW-1:0] wds [NS];

    // Expected results of the last full frame sent
    bit            pend = 0;
    bit            have_held = 0;
    logic          exp_fv;
    logic [NS-1:0] exp_sv, exp_err;
    logic [NS*SW-1:0] exp_data, held_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    aclink_rx_frame uut (
        .bclk_i(clk), .rst_i(rst), .sync_i(sync), .sdata_i(sdata),
        .frame_done_o(frame_done), .frame_valid_o(frame_valid),
        .slot_valid_o(slot_valid), .slot_data_o(slot_data),
        .slot_fill_err_o(slot_fill_err), .sync_err_o(sync_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [NS*SW-1:0] act, input logic [NS*SW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic frame_bit(input int b);
        if (b < 16) return cur_tag[15-b];
        return wds[(b-16)/SW][SW-1-((b-16)%SW)];
    endfunction

    // Expected per-frame outputs, worked out from R3, R4 and R7.
    task automatic set_expected();
        exp_fv = cur_tag[15];
        for (int i = 0; i < NS; i++) begin
            exp_sv[i] = cur_tag[14-i];
            exp_data[i*SW +: SW] = wds[i];
            exp_err[i] = !cur_tag[14-i] && (wds[i] != '0);
        end
    endtask

    task automatic check_prev_frame();
        check(frame_done == 1'b1, "R5", "done strobe after bit 255", frame_done, 1);
        check(frame_valid == exp_fv, "R3", "frame valid", frame_valid, exp_fv);
        check(slot_valid == exp_sv, "R3", "slot valid", slot_valid, exp_sv);
        check(slot_data == exp_data, "R4", "slot data", slot_data, exp_data);
        check(slot_fill_err == exp_err, "R7", "fill error", slot_fill_err, exp_err);
        held_data = exp_data;
        have_held = 1;
    endtask

    // Drives one frame (or the first nbits of one). Inputs change after the
    // rising edge; the design samples on the falling edge.
    task automatic send_frame(input int nbits, input int sync_len, input logic exp_serr);
        for (int b = 0; b < nbits; b++) begin
            @(posedge clk);
            if (b == 0 && pend) begin
                check_prev_frame();
                pend = 0;
            end
            if (b == 1) begin
                check(frame_done == 1'b0, "R5", "strobe one cycle", frame_done, 0);
                check(sync_err == exp_serr, "R8", "sync error pulse", sync_err, exp_serr);
            end
            if (b == 2)
                check(sync_err == 1'b0, "R8", "sync error cleared", sync_err, 0);
            if (b == 128 && have_held) begin
                check(frame_done == 1'b0, "R5", "no strobe mid frame", frame_done, 0);
                check(slot_data == held_data, "R6", "outputs held", slot_data, held_data);
            end
            sync  = (b < sync_len);
            sdata = frame_bit(b);
        end
        if (nbits == 16 + NS*SW) begin
            set_expected();
            pend = 1;
        end
    endtask

    task automatic fill_random();
        cur_tag = 16'($urandom);
        for (int i = 0; i < NS; i++) begin
            if (cur_tag[14-i] || ($urandom % 4 == 0))
                wds[i] = SW'($urandom) | SW'(($urandom % 2 == 0) ? 1 : 0);
            else
                wds[i] = '0;
        end
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(posedge clk);
        // R1: reset state
        check(frame_done == 0 && frame_valid == 0 && sync_err == 0, "R1",
              "control outputs after reset", {frame_done, frame_valid, sync_err}, 0);
        check(slot_data == '0 && slot_valid == '0 && slot_fill_err == '0, "R1",
              "data outputs after reset", slot_data, 0);

        // R2: noise with SYNC low never decodes
        begin
            bit seen = 0;
            for (int k = 0; k < 300; k++) begin
                @(posedge clk);
                if (frame_done) seen = 1;
                sync  = 1'b0;
                sdata = 1'($urandom);
            end
            check(!seen && frame_valid == 0, "R2", "no frame before first SYNC rise",
                  {seen, frame_valid}, 0);
        end

        // Directed: every slot tagged valid and full of ones (R3, R4)
        cur_tag = 16'hFFF8;
        for (int i = 0; i < NS; i++) wds[i] = '1;
        send_frame(256, 16, 1'b0);

        // Directed: empty tag, one stray nonzero word in slot 5 (R7)
        cur_tag = 16'h0007;
        for (int i = 0; i < NS; i++) wds[i] = '0;
        wds[4] = 20'h00010;
        send_frame(256, 16, 1'b0);

        // Directed: distinct slot patterns check ordering (R4)
        cur_tag = 16'hA5A0;
        for (int i = 0; i < NS; i++) wds[i] = SW'(20'h80001 ^ (i << 8) ^ (i + 1));
        send_frame(256, 16, 1'b0);

        // R9: SYNC held high for 40 bits
        fill_random();
        send_frame(256, 40, 1'b0);

        // R8: frame cut at bit 100, next SYNC rise arrives early
        fill_random();
        send_frame(256, 16, 1'b0);
        fill_random();
        send_frame(100, 16, 1'b0);
        fill_random();
        send_frame(256, 16, 1'b1);

        // Random frames
        for (int f = 0; f < 20; f++) begin
            fill_random();
            send_frame(256, 16 + (($urandom % 4 == 0) ? int'($urandom % 30) : 0), 1'b0);
        end

        @(posedge clk);
        if (pend) check_prev_frame();
        sync = 1'b0;
        @(posedge clk);
        check(frame_done == 1'b0, "R5", "strobe cleared at end", frame_done, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule